// File: doc/BRIEF.md
# Serial-Programmed Clock Output Enable Controller

This block receives a fixed-format write over a two-wire serial bus and uses it to turn each of seven copies of a reference clock on or off. The bus lines are sampled with a fast system clock. A falling data line while the clock line is high opens a transfer, and a rising data line while the clock line is high closes it. The slave shifts in each byte most significant bit first and acknowledges it by pulling the data line low through an open-drain style output.

Only a write to bus byte value 0xD2 is accepted. That byte is followed by two filler bytes, which are acknowledged and otherwise ignored, and then by up to ten data bytes. The first data byte fills enable register A and the second fills enable register B. The slave has no read path and no subaddressing.

Each enable bit is carried into the reference clock domain and applied only while the reference clock is low. A stopped output therefore sits low, and an output being started or stopped never shows a shortened pulse.

Top module: `clkgate_i2c_ctrl`

## Requirements
- R1: A falling `sdaIn` while `sclIn` is high begins a transfer at the address phase, even in the middle of another transfer. A rising `sdaIn` while `sclIn` is high ends the transfer. Bytes clocked while no transfer is open are not acknowledged.
- R2: Bytes are received MSB first on rising `sclIn`. An accepted byte is acknowledged by `sdaDriveLow` = 1, which is raised while `sclIn` is low after the eighth bit and held through the whole high phase of the ninth clock.
- R3: Only the address byte 0xD2 is acknowledged. Any other value, including the read value 0xD3, gets no acknowledge, and the rest of that transfer changes nothing.
- R4: The two bytes after the address are acknowledged whatever their values, and they change no enable.
- R5: Data byte 1 loads register A and data byte 2 loads register B. A transfer with a single data byte leaves register B unchanged.
- R6: Data bytes 1 to 10 are acknowledged. Byte 11 and later get no acknowledge. Bytes 3 and later change no enable.
- R7: In register A, bit 2 enables output 0, bit 3 enables output 1 and bit 7 enables output 2. Bits 0, 1, 4, 5 and 6 have no effect.
- R8: In register B, bit 2 enables output 3, bit 3 enables output 4, bit 6 enables output 5 and bit 7 enables output 6. Bits 0, 1, 4 and 5 have no effect.
- R9: After reset both registers hold all ones, so every output is enabled, and `sdaDriveLow` is 0.
- R10: An enabled `clkOut[i]` follows `refClk` and a stopped one stays low. Every edge of `clkOut[i]` coincides with the matching edge of `refClk`, so no shortened pulses occur.
- R11: A stop, or a new start, in the middle of a byte keeps every register that has already been loaded in that transfer, and loads no partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial bus clock line |
| sdaIn | input | 1 | Serial bus data line, as seen on the wire |
| sdaDriveLow | output | 1 | When 1, the data line is pulled low (acknowledge) |
| refClk | input | 1 | Reference clock that is fanned out |
| clkOut | output | 7 | Gated copies of the reference clock |

## Verification
Two events can fall in the same cycle. A register load fires on the same system clock edge that raises the acknowledge, while the reference-clock gate for an output can close on a falling `refClk` edge at any moment during the transfer. The bench drives the reference clock at a period unrelated to the system clock, and sweeps 32 enable patterns with changing reserved bits. For every pattern it compares the acknowledge bits and the observed output activity with values computed from the bit map. An edge monitor checks each output edge against the time stamp of the matching `refClk` edge, to confirm that a gate change never cuts a pulse short.

// File: rtl/cgc_pkg.sv
`timescale 1ns/1ps
package cgc_pkg;
  localparam int NUM_OUT = 7;
  localparam int BYTE_W  = 8;

  // output index -> register select (0 = A, 1 = B) and bit position
  localparam int unsigned EN_REG [NUM_OUT] = '{0, 0, 0, 1, 1, 1, 1};
  localparam int unsigned EN_BIT [NUM_OUT] = '{2, 3, 7, 2, 3, 6, 7};

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_DATA
  } cgc_state_t;

  typedef struct packed {
    logic              loadA;
    logic              loadB;
    logic [BYTE_W-1:0] data;
  } cgc_strobe_t;
endpackage

// File: rtl/cgc_ctrl.sv
`timescale 1ns/1ps
module cgc_ctrl
  import cgc_pkg::*;
#(
  parameter logic [7:0] ADDR_BYTE = 8'hD2,
  parameter int         MAX_DATA  = 10,
  parameter int         CW        = $clog2(MAX_DATA + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaDriveLow,
  output cgc_strobe_t strobe
);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_DATA);

  logic [1:0] sclSync, sdaSync;
  logic       sclS, sdaS, sclP, sdaP;
  logic       startC, stopC, sclRise, sclFall;
  cgc_state_t state;
  logic [3:0] bitCnt;
  logic       inAck;
  logic [7:0] shiftReg;
  logic [CW-1:0] dataCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1; sdaSync <= '1; sclP <= 1'b1; sdaP <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclP    <= sclSync[1];
      sdaP    <= sdaSync[1];
    end
  end

  assign sclS    = sclSync[1];
  assign sdaS    = sdaSync[1];
  assign startC  = sclS & sclP & sdaP & ~sdaS;
  assign stopC   = sclS & sclP & ~sdaP & sdaS;
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; bitCnt <= '0; inAck <= 1'b0; shiftReg <= '0;
      dataCnt <= '0; sdaDriveLow <= 1'b0; strobe <= '0;
    end else begin
      strobe.loadA <= 1'b0;
      strobe.loadB <= 1'b0;
      if (startC || stopC) begin
        state       <= startC ? ST_ADDR : ST_IDLE;
        bitCnt      <= '0;
        inAck       <= 1'b0;
        sdaDriveLow <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (sclRise && !inAck && bitCnt != 4'd8) begin
          shiftReg <= {shiftReg[6:0], sdaS};
          bitCnt   <= bitCnt + 4'd1;
        end else if (sclFall && !inAck && bitCnt == 4'd8) begin
          inAck <= 1'b1;
          unique case (state)
            ST_ADDR: begin
              if (shiftReg == ADDR_BYTE) sdaDriveLow <= 1'b1;
              else                       state       <= ST_IDLE;
            end
            ST_CMD, ST_CNT: sdaDriveLow <= 1'b1;
            ST_DATA: begin
              if (dataCnt < MAX_C) begin
                sdaDriveLow  <= 1'b1;
                dataCnt      <= dataCnt + 1'b1;
                strobe.loadA <= (dataCnt == '0);
                strobe.loadB <= (dataCnt == CW'(1));
                strobe.data  <= shiftReg;
              end
            end
            default: ;
          endcase
        end else if (sclFall && inAck) begin
          inAck       <= 1'b0;
          sdaDriveLow <= 1'b0;
          bitCnt      <= '0;
          unique case (state)
            ST_ADDR: state <= ST_CMD;
            ST_CMD:  state <= ST_CNT;
            ST_CNT: begin
              state   <= ST_DATA;
              dataCnt <= '0;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cgc_regs.sv
`timescale 1ns/1ps
module cgc_regs
  import cgc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cgc_strobe_t        strobe,
  output logic [NUM_OUT-1:0] enVec
);
  logic [BYTE_W-1:0] regA, regB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '1;
      regB <= '1;
    end else begin
      if (strobe.loadA) regA <= strobe.data;
      if (strobe.loadB) regB <= strobe.data;
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_map
    if (EN_REG[g] == 0) begin : g_a
      assign enVec[g] = regA[EN_BIT[g]];
    end else begin : g_b
      assign enVec[g] = regB[EN_BIT[g]];
    end
  end
endmodule

// File: rtl/cgc_gate.sv
`timescale 1ns/1ps
module cgc_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic enIn,
  output logic clkOut
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   gateQ;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], enIn};
  end

  // gate changes only on the falling edge, while refClk is low
  always_ff @(negedge refClk or negedge rstN) begin
    if (!rstN) gateQ <= 1'b1;
    else       gateQ <= syncQ[SYNC_STAGES-1];
  end

  assign clkOut = refClk & gateQ;
endmodule

// File: rtl/clkgate_i2c_ctrl.sv
`timescale 1ns/1ps
module clkgate_i2c_ctrl
  import cgc_pkg::*;
#(
  parameter logic [7:0] ADDR_BYTE   = 8'hD2,
  parameter int         MAX_DATA    = 10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaDriveLow,
  input  logic               refClk,
  output logic [NUM_OUT-1:0] clkOut
);
  cgc_strobe_t        ctrlStrobe;
  logic [NUM_OUT-1:0] enVec;

  cgc_ctrl #(.ADDR_BYTE(ADDR_BYTE), .MAX_DATA(MAX_DATA)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaDriveLow(sdaDriveLow), .strobe(ctrlStrobe)
  );

  cgc_regs uRegs (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe), .enVec(enVec)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    cgc_gate #(.SYNC_STAGES(SYNC_STAGES)) uGate (
      .refClk(refClk), .rstN(rstN), .enIn(enVec[g]), .clkOut(clkOut[g])
    );
  end
endmodule

// File: rtl/cgc_check.sv
`timescale 1ns/1ps
module cgc_check #(
  parameter int MAX_DATA = 10,
  parameter int CW       = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          sdaDriveLow,
  input logic          sclSync,
  input logic          loadA,
  input logic          loadB,
  input logic [6:0]    enVec,
  input logic [CW-1:0] dataCnt
);
  AST_ACK_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclSync); // R2
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadA, loadB})); // R5
  AST_LOAD_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (loadA || loadB) |-> sdaDriveLow); // R6
  AST_DATA_CAP: assert property (@(posedge clk) disable iff (!rstN)
    dataCnt <= CW'(MAX_DATA)); // R6
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !(loadA || loadB) |=> $stable(enVec)); // R11
  AST_RESET_ALL_ON: assert property (@(posedge clk)
    !rstN |=> enVec == 7'h7F); // R9
endmodule

bind clkgate_i2c_ctrl cgc_check #(.MAX_DATA(MAX_DATA), .CW($clog2(MAX_DATA + 1))) uChk (
  .clk(clk), .rstN(rstN), .sdaDriveLow(sdaDriveLow), .sclSync(uCtrl.sclS),
  .loadA(ctrlStrobe.loadA), .loadB(ctrlStrobe.loadB), .enVec(enVec),
  .dataCnt(uCtrl.dataCnt)
);

// File: tb/clkgate_i2c_ctrl_test.sv
`timescale 1ns/1ps
module clkgate_i2c_ctrl_test;
  localparam int Q = 5;

  logic       clk = 1'b0, rstN = 1'b1, refClk = 1'b0;
  logic       sclM = 1'b1, sdaM = 1'b1;
  wire        sdaDriveLow;
  wire  [6:0] clkOut;
  wire        sdaLine = sdaM & ~sdaDriveLow;

  int nChk = 0, nErr = 0, edges = 0, glitchErr = 0;
  realtime tRefRise = 0, tRefFall = 0;
  logic [7:0]  txb [16];
  logic [15:0] acks;
  logic [6:0]  seen, prevOut = '0;

  clkgate_i2c_ctrl uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .refClk(refClk), .clkOut(clkOut)
  );

  always #2.5 clk = ~clk;
  initial forever begin
    #19 tRefRise = $realtime; refClk = 1'b1;
    #19 tRefFall = $realtime; refClk = 1'b0;
  end

  // R10 edge monitor: output edges only together with refClk edges
  always @(clkOut) begin
    if (rstN) begin
      for (int i = 0; i < 7; i++) begin
        if (clkOut[i] !== prevOut[i]) begin
          edges++;
          if (clkOut[i] && $realtime != tRefRise) glitchErr++;
          if (!clkOut[i] && $realtime != tRefFall) glitchErr++;
        end
      end
    end
    prevOut = clkOut;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; wq(); sclM = 1'b1; wq(); sdaM = 1'b0; wq(); sclM = 1'b0; wq();
  endtask

  task automatic stopC();
    sdaM = 1'b0; wq(); sclM = 1'b1; wq(); sdaM = 1'b1; wq(); wq();
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = v[i]; wq(); sclM = 1'b1; wq(); wq(); sclM = 1'b0; wq();
    end
  endtask

  task automatic ackSlot(output logic a);
    sdaM = 1'b1; wq(); sclM = 1'b1; wq(); a = ~sdaLine; wq(); sclM = 1'b0; wq();
  endtask

  task automatic sendBytes(input int nb);
    logic a;
    acks = '0;
    for (int i = 0; i < nb; i++) begin
      sendBits(txb[i], 8);
      ackSlot(a);
      acks[i] = a;
    end
  endtask

  task automatic observe();
    repeat (80) @(negedge clk);
    seen = '0;
    repeat (40) begin
      @(negedge clk);
      seen |= clkOut;
    end
  endtask

  function automatic logic [6:0] mapEn(input logic [7:0] ra, input logic [7:0] rb);
    return {rb[7], rb[6], rb[3], rb[2], ra[7], ra[3], ra[2]};
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  endtask

  initial begin
    #900us;
    nChk++; nErr++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] ra, rb, rs;
    logic [6:0] en, cur;
    logic a;
    #1 rstN = 1'b0;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    observe();
    check("R9 reset enables", {25'd0, seen}, 32'h7F);
    check("R9 reset ack idle", {31'd0, sdaDriveLow}, 32'd0);

    // R7 R8 R4 sweep: 32 enable patterns, changing reserved and filler bytes
    for (int k = 0; k < 32; k++) begin
      en = 7'((k * 37) % 128);
      rs = ~8'(k);
      ra = {en[2], rs[4:2], en[1], en[0], rs[1:0]};
      rb = {en[6], en[5], rs[3:2], en[4], en[3], rs[1:0]};
      txb[0] = 8'hD2; txb[1] = 8'(k); txb[2] = ~8'(k * 3); txb[3] = ra; txb[4] = rb;
      startC(); sendBytes(5); stopC();
      check("R2 R4 sweep acks", {16'd0, acks}, 32'h1F);
      observe();
      check("R7 R8 sweep enables", {25'd0, seen}, {25'd0, mapEn(ra, rb)});
    end
    cur = seen;

    // R3 wrong address and read request
    txb[0] = 8'hD4; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00; txb[4] = 8'h00;
    startC(); sendBytes(5); stopC();
    check("R3 foreign address acks", {16'd0, acks}, 32'h0);
    observe();
    check("R3 foreign address enables", {25'd0, seen}, {25'd0, cur});
    txb[0] = 8'hD3;
    startC(); sendBytes(5); stopC();
    check("R3 read request acks", {16'd0, acks}, 32'h0);
    observe();
    check("R3 read request enables", {25'd0, seen}, {25'd0, cur});

    // R6 twelve data bytes
    txb[0] = 8'hD2; txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'hFF; txb[4] = 8'hFF;
    for (int i = 5; i < 15; i++) txb[i] = 8'h00;
    startC(); sendBytes(15); stopC();
    check("R6 ack limit", {16'd0, acks}, 32'h1FFF);
    observe();
    check("R6 extra bytes ignored", {25'd0, seen}, 32'h7F);

    // R5 single data byte leaves register B
    txb[3] = 8'h00;
    startC(); sendBytes(4); stopC();
    check("R5 single byte acks", {16'd0, acks}, 32'hF);
    observe();
    check("R5 register B kept", {25'd0, seen}, 32'h78);

    // R1 R11 repeated start mid-byte
    startC(); sendBits(8'hD2, 8); ackSlot(a); sendBits(8'h00, 8); ackSlot(a);
    sendBits(8'h00, 3);
    txb[1] = 8'h5A; txb[2] = 8'hA5; txb[3] = 8'h0C; txb[4] = 8'h40;
    startC(); sendBytes(5); stopC();
    check("R1 R11 restart acks", {16'd0, acks}, 32'h1F);
    observe();
    check("R11 restart enables", {25'd0, seen}, 32'h23);

    // R11 stop mid-byte after register A load
    txb[3] = 8'h80;
    startC(); sendBytes(4); sendBits(8'h00, 3); stopC();
    observe();
    check("R11 stop mid-byte", {25'd0, seen}, 32'h24);

    // R1 bytes with no open transfer
    sendBits(8'hD2, 8); ackSlot(a);
    check("R1 no start no ack", {31'd0, a}, 32'd0);
    sendBits(8'h00, 8); ackSlot(a); sendBits(8'h00, 8); ackSlot(a);
    sendBits(8'h00, 8); ackSlot(a);
    observe();
    check("R1 no start enables", {25'd0, seen}, 32'h24);

    // R10 no shortened pulses across all gate changes
    check("R10 edge alignment", glitchErr, 0);
    check("R10 edges seen", {31'd0, edges > 100}, 32'd1);
    finishRun();
  end
endmodule